// File: doc/BRIEF.md
# Modem Line Control and Status Register Pair

This block holds the two modem-facing registers of a serial port. A control register written by software drives four modem outputs, Data Terminal Ready, Request To Send and two general-purpose outputs (the second of which serves as the interrupt gate), and carries a loopback enable. A status register reports the current levels of the four modem inputs: Clear To Send, Data Set Ready, Ring Indicator and Data Carrier Detect. It also keeps sticky change flags for those inputs. A modem interrupt request is raised while any change flag is set.

The external inputs first pass through a multi-flop synchronizer. They are then captured into a level register, and change flags are derived from that register. Reading the status register returns levels and flags together and clears the flags. In loopback mode the pins are ignored and the control bits are routed internally onto the status inputs, so software can exercise the whole status path without a modem. During loopback the physical outputs are held inactive.

All signals are active-high: a 1 means the line is asserted. Accesses are single-cycle strobes. Read data appears on `rdata` one cycle after the strobe and holds until the next read.

Top module: `modem_ctl_status`

## Requirements
- R1: A write with `addr`=0 stores `wdata[4:0]` as the control value: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. A read with `addr`=0 returns that value with bits [7:5] as 0. Outside loopback, the outputs `dtr_o`, `rts_o`, `out1_o` and `out2_o` follow bits 0..3 from the cycle after the write.
- R2: A read with `addr`=1 returns the status byte. Bit 7 is the DCD level, bit 6 RI, bit 5 DSR and bit 4 CTS. An external pin level reaches these bits three clock edges after it is applied: two synchronizer flops and the level register.
- R3: Status bits 3, 1 and 0 are set on any change, either direction, of the DCD, DSR and CTS levels respectively. They stay set until a status read.
- R4: Status bit 2 is set only when the RI level goes from 1 to 0. A 0-to-1 transition of RI leaves it unchanged.
- R5: A status read returns the change bits as they were before the read, then clears them. A change detected in the same cycle as the read leaves its bit set.
- R6: While loopback is enabled, all four modem outputs are 0.
- R7: While loopback is enabled, the external pins are ignored. DSR takes DTR, CTS takes RTS, RI takes OUT1 and DCD takes OUT2, all from the control register.
- R8: `irq` is 1 exactly when at least one of the four change bits is set.
- R9: A write with `addr`=1 has no effect on any register or output.
- R10: After synchronous reset, the control value, status byte, outputs, `irq` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | 0 = control register, 1 = status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cts_i | input | 1 | Clear To Send pin, asynchronous |
| dsr_i | input | 1 | Data Set Ready pin, asynchronous |
| ri_i | input | 1 | Ring Indicator pin, asynchronous |
| dcd_i | input | 1 | Data Carrier Detect pin, asynchronous |
| dtr_o | output | 1 | Data Terminal Ready output |
| rts_o | output | 1 | Request To Send output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 / interrupt gate |
| irq | output | 1 | Modem interrupt request |

## Verification
The status path is driven with single-pin toggles, which show whether each change bit is wired to its own line. RI is driven separately in both directions to separate a trailing-edge detector from a plain change detector. Loopback is entered with the control bits high while the pins are toggling, so a leak from the pins or a swapped feed mapping shows up in the level bits. A long stretch of random pin levels with interleaved status reads then lands changes in the same cycle as a read, which exposes a clear that wins over a new set.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int REG_W   = 8;
  localparam int LINES_W = 4;
  localparam int CTL_W   = 5;
  // positions of the modem inputs inside a level/change nibble
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  // positions inside the control value
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import modem_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_ctl,
  input  logic [CTL_W-1:0]   wval,
  output logic [CTL_W-1:0]   ctl_q,
  output logic [LINES_W-1:0] pins_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      pins_q <= '0;
    end else if (wr_ctl) begin
      ctl_q  <= wval;
      pins_q <= wval[C_LOOP] ? '0 : wval[LINES_W-1:0];
    end
  end

  // R6: loopback keeps every modem output low
  a_r6_pins_quiet: assert property (@(posedge clk) disable iff (rst)
    ctl_q[C_LOOP] |-> (pins_q == '0));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import modem_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_stat,
  input  logic [LINES_W-1:0] ext_s,
  input  logic [CTL_W-1:0]   ctl,
  output logic [LINES_W-1:0] lvl_q,
  output logic [LINES_W-1:0] delta_q,
  output logic               irq_q
);
  logic [LINES_W-1:0] lb_src, src, set_v, delta_n;

  always_comb begin
    lb_src        = '0;
    lb_src[L_CTS] = ctl[C_RTS];
    lb_src[L_DSR] = ctl[C_DTR];
    lb_src[L_RI]  = ctl[C_OUT1];
    lb_src[L_DCD] = ctl[C_OUT2];
    src = ctl[C_LOOP] ? lb_src : ext_s;
  end

  for (genvar i = 0; i < LINES_W; i++) begin : g_chg
    if (i == L_RI) begin : g_trail
      assign set_v[i] = lvl_q[i] & ~src[i];
    end else begin : g_any
      assign set_v[i] = lvl_q[i] ^ src[i];
    end
  end

  assign delta_n = (rd_stat ? '0 : delta_q) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      delta_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      lvl_q   <= src;
      delta_q <= delta_n;
      irq_q   <= |delta_n;
    end
  end

  // R4: RI change flag only rises on a falling RI level
  a_r4_ri_trailing: assert property (@(posedge clk) disable iff (rst)
    $rose(delta_q[L_RI]) |-> ($past(lvl_q[L_RI]) && !lvl_q[L_RI]));
  // R5: a read with no new change empties the flags
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && (src == lvl_q)) |=> (delta_q == '0));
  // R3: a flag without a read stays set
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rd_stat && delta_q[L_CTS]) |=> delta_q[L_CTS]);
  // R8: request tracks the flags
  a_r8_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq_q == (delta_q != '0));
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             cts_i,
  input  logic             dsr_i,
  input  logic             ri_i,
  input  logic             dcd_i,
  output logic             dtr_o,
  output logic             rts_o,
  output logic             out1_o,
  output logic             out2_o,
  output logic             irq
);
  localparam int PAD_W = REG_W - CTL_W;

  logic [LINES_W-1:0] pins_raw, pins_s, lvl, delta, outs;
  logic [CTL_W-1:0]   ctl;
  logic               wr_ctl, rd_stat;
  logic               unused_hi;

  assign unused_hi = ^wdata[REG_W-1:CTL_W];

  always_comb begin
    pins_raw        = '0;
    pins_raw[L_CTS] = cts_i;
    pins_raw[L_DSR] = dsr_i;
    pins_raw[L_RI]  = ri_i;
    pins_raw[L_DCD] = dcd_i;
  end

  assign wr_ctl  = wr_en & ~addr;
  assign rd_stat = rd_en & addr;

  mdm_sync #(.WIDTH(LINES_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_raw), .q_o(pins_s));

  mdm_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wval(wdata[CTL_W-1:0]),
    .ctl_q(ctl), .pins_q(outs));

  mdm_status u_stat (
    .clk(clk), .rst(rst), .rd_stat(rd_stat), .ext_s(pins_s), .ctl(ctl),
    .lvl_q(lvl), .delta_q(delta), .irq_q(irq));

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= addr ? {lvl, delta} : {{PAD_W{1'b0}}, ctl};
  end

  assign dtr_o  = outs[C_DTR];
  assign rts_o  = outs[C_RTS];
  assign out1_o = outs[C_OUT1];
  assign out2_o = outs[C_OUT2];

  // R9: a status write leaves the control value alone
  a_r9_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr) |=> $stable(ctl));
  // R1: a control read returns zero upper bits
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr) |=> (rdata[REG_W-1:CTL_W] == '0));
endmodule

// File: tb/test_modem_ctl_status.sv
module test_modem_ctl_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
  logic dtr_o, rts_o, out1_o, out2_o, irq;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  modem_ctl_status i_modem_ctl_status (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cts_i(cts), .dsr_i(dsr), .ri_i(ri),
    .dcd_i(dcd), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o),
    .out2_o(out2_o), .irq(irq));

  // behavioural reference: nibble order {DCD,RI,DSR,CTS}
  logic [3:0] sy1 = '0, sy2 = '0, lv = '0, dl = '0, pin = '0;
  logic [4:0] ctl = '0;
  logic [7:0] rd  = '0;
  logic       mirq = 1'b0;

  task automatic model_edge();
    logic [3:0] src, setb, ndl;
    logic [7:0] nrd;
    if (rst) begin
      sy1 = '0; sy2 = '0; lv = '0; dl = '0; pin = '0; ctl = '0; rd = '0; mirq = 0;
    end else begin
      src  = ctl[4] ? {ctl[3], ctl[2], ctl[0], ctl[1]} : sy2;
      setb = {lv[3] != src[3], lv[2] && !src[2], lv[1] != src[1], lv[0] != src[0]};
      nrd  = rd;
      if (rd_en) nrd = addr ? {lv, dl} : {3'b000, ctl};
      ndl  = ((rd_en && addr) ? 4'h0 : dl) | setb;
      sy2 = sy1; sy1 = {dcd, ri, dsr, cts};
      lv = src; dl = ndl; mirq = (ndl != 0); rd = nrd;
      if (wr_en && !addr) begin
        ctl = wdata[4:0];
        pin = wdata[4] ? 4'h0 : wdata[3:0];
      end
    end
  endtask

  task automatic compare(string tag);
    vectors++;
    if ({out2_o, out1_o, rts_o, dtr_o} !== pin) begin
      fails++;
      $display("FAIL R1 R6 %s outputs: actual %b expected %b", tag,
               {out2_o, out1_o, rts_o, dtr_o}, pin);
    end
    vectors++;
    if (rdata !== rd) begin
      fails++;
      $display("FAIL R2 R3 R4 R5 R7 R9 %s rdata: actual %h expected %h", tag, rdata, rd);
    end
    vectors++;
    if (irq !== mirq) begin
      fails++;
      $display("FAIL R8 %s irq: actual %b expected %b", tag, irq, mirq);
    end
  endtask

  task automatic cyc(string tag);
    model_edge();
    @(negedge clk);
    compare(tag);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d, string tag);
    wr_en = 1; addr = a; wdata = d; cyc(tag);
  endtask

  task automatic rdr(logic a, string tag);
    rd_en = 1; addr = a; cyc(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pins(logic [3:0] v);
    {dcd, ri, dsr, cts} = v;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1;
    idle(3, "R10 reset");
    rst = 0;
    rdr(0, "R10 reset ctl"); rdr(1, "R10 reset status");
    wr(0, 8'hEF, "R1 ctl write");
    rdr(0, "R1 ctl read");
    wr(1, 8'hFF, "R9 status write");
    rdr(0, "R9 ctl unchanged"); rdr(1, "R9 status unchanged");
    // single pin toggles: R3 and R4
    for (int b = 0; b < 4; b++) begin
      pins(4'(1 << b)); idle(4, "R2 R3 rise"); rdr(1, "R3 R4 read after rise");
      pins(4'h0);       idle(4, "R3 R4 fall"); rdr(1, "R4 read after fall");
      rdr(1, "R5 cleared");
    end
    // loopback with control bits high, pins toggling
    wr(0, 8'h1F, "R6 R7 loop on");
    for (int i = 0; i < 8; i++) begin
      pins(4'(i * 5)); cyc("R7 pins ignored");
    end
    rdr(1, "R7 loop levels"); rdr(1, "R5 clear in loop");
    wr(0, 8'h11, "R7 loop partial"); idle(3, "R7 loop");
    rdr(1, "R4 R7 ri fall in loop");
    wr(0, 8'h00, "R1 loop off"); pins(4'h0); idle(5, "R2 settle");
    rdr(1, "R5 flush");
    // random stretch: reads collide with changes
    for (int i = 0; i < 3000; i++) begin
      pins(4'($urandom_range(0, 15)));
      case ($urandom_range(0, 7))
        0, 1, 2: rdr(1, "R5 random read");
        3:       wr(0, 8'($urandom_range(0, 255)), "R1 R6 random ctl");
        4:       wr(1, 8'($urandom_range(0, 255)), "R9 random");
        5:       rdr(0, "R1 random ctl read");
        default: cyc("R3 R8 random idle");
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule